// File: doc/BRIEF.md
# Host Command Sequencer with Link Watchdog

This block is the top-level controller between a host computer and a high-voltage output stage. Host bytes arrive one per cycle from a byte-wide USB FIFO. The block scans that stream for a three-byte command frame. The frame is a sync byte 0xFF, then a zero byte 0x00, then one control byte. The control byte selects one action: refresh every output channel, run the self-test, power the amplifiers down, report status, or only restart the watchdog. The refresh engine, the self-test engine and the amplifier power sequencer sit outside the block. Each is reached through a one-cycle start pulse and a done strobe.

After reset the block waits for the USB link to report ready, then asks for amplifier power-up. Once powered, it sits in an idle state and waits for commands. Replies go back through a valid/ready byte port. Each reply is one payload byte followed by an end-of-transmission byte, 0x04. The watchdog counts idle cycles. If the host sends no defined command for `WDT_CYCLES` consecutive idle cycles, the block powers the amplifiers down on its own and latches a fault flag. After any power-down the block stays off and answers only status requests until the next reset.

Top module: `host_cmd_seq`

## Requirements
- R1: While reset is applied, `tx_valid`, all four start pulses, `amps_on` and `wdt_fault` are 0.
- R2: After reset the block issues no `pwr_up_start` until `link_ready` has been seen high, and commands received before then have no effect. Once `link_ready` is high, one `pwr_up_start` pulse follows. `pwr_up_done` then brings `amps_on` to 1 and enters idle.
- R3: A frame is 0xFF, 0x00, then a control byte. The defined control bytes are 0x01 (refresh), 0x02 (self-test), 0x03 (power-down), 0x05 (status) and 0x06 (watchdog restart). In idle, the start pulse for a command is high in the second cycle after the cycle that delivers the control byte.
- R4: A wrong byte in the header position discards the partial frame. A 0xFF in any position, including the control position, restarts header matching at that byte.
- R5: Control bytes outside the defined set (0x00 for example) start nothing, produce no reply and do not restart the watchdog.
- R6: Refresh pulses `refresh_start` and returns to idle on `refresh_done`. Frames that arrive while the refresh is busy are ignored.
- R7: Self-test pulses `test_start`. On `test_done` the block sends 0x01 if `test_pass` was high and 0x00 otherwise, then 0x04.
- R8: Status sends one byte, then 0x04. The status byte holds: bit0 amplifiers on, bit1 watchdog fault, bit2 last self-test failed, bit3 a self-test has completed since reset, bits 7:4 zero.
- R9: Each reply byte stays on `tx_data` with `tx_valid` high until it is accepted with `tx_ready`.
- R10: Power-down pulses `pwr_dn_start` and drops `amps_on` in the same cycle. After `pwr_dn_done` the block stays off. There it answers status and ignores every other command.
- R11: If `WDT_CYCLES` idle cycles pass with no defined command, the block starts power-down and sets `wdt_fault`. The flag stays set until reset. An explicit power-down command does not set it.
- R12: Start pulses last exactly one cycle, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_ready | input | 1 | USB link reports ready |
| rx_valid | input | 1 | Host byte present this cycle |
| rx_data | input | 8 | Host byte |
| tx_valid | output | 1 | Reply byte offered |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | Reply byte accepted |
| pwr_up_start | output | 1 | Request amplifier power-up |
| pwr_up_done | input | 1 | Power-up complete |
| pwr_dn_start | output | 1 | Request amplifier power-down |
| pwr_dn_done | input | 1 | Power-down complete |
| refresh_start | output | 1 | Request full output refresh |
| refresh_done | input | 1 | Refresh complete |
| test_start | output | 1 | Request self-test |
| test_done | input | 1 | Self-test complete |
| test_pass | input | 1 | Self-test result, valid with `test_done` |
| amps_on | output | 1 | Amplifiers are powered |
| wdt_fault | output | 1 | Sticky watchdog fault |

## Verification
Frame detection is driven with directed streams, each aimed at one rule:
- a header broken by a wrong byte;
- a doubled sync byte;
- a sync byte in the control position followed by a full header;
- undefined control bytes.

Each stream shows whether the detector resets, restarts or emits a command. Constrained-random passes add noise taken only from sync, zero and undefined bytes, then a real frame. A wrong command or a shifted trigger point therefore shows up as a wrong or late start pulse. Reply ports are stalled at random, which separates correct byte holding from dropped or changed bytes. The watchdog is hit exactly one cycle before and at its limit, with an undefined frame inside the window. This tells a correct count apart from one that undefined bytes restart.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t HDR_SYNC = 8'hFF;
  localparam byte_t HDR_ZERO = 8'h00;
  localparam byte_t EOT_BYTE = 8'h04;

  localparam byte_t CMD_REFRESH = 8'h01;
  localparam byte_t CMD_SELFTST = 8'h02;
  localparam byte_t CMD_PWRDOWN = 8'h03;
  localparam byte_t CMD_STATUS  = 8'h05;
  localparam byte_t CMD_KICK    = 8'h06;

  typedef enum logic [2:0] {
    ST_BOOT, ST_PWRUP, ST_IDLE, ST_REFRESH,
    ST_TEST, ST_REPLY, ST_PWRDN, ST_OFF
  } ctl_state_t;

  typedef enum logic [1:0] {HD_HUNT, HD_SYNC, HD_ZERO} hdr_state_t;

  typedef enum logic [1:0] {TX_IDLE, TX_PAYLOAD, TX_EOT} tx_phase_t;

  function automatic logic cmd_known(input byte_t c);
    return c inside {CMD_REFRESH, CMD_SELFTST, CMD_PWRDOWN, CMD_STATUS, CMD_KICK};
  endfunction
endpackage

// File: rtl/hcs_rst_sync.sv
module hcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/hcs_frame_detect.sv
module hcs_frame_detect
  import hcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  input  byte_t in_byte,
  output logic  cmd_valid,
  output byte_t cmd_byte
);
  hdr_state_t hs_q, hs_d;
  logic       emit_d;

  always_comb begin
    hs_d   = hs_q;
    emit_d = 1'b0;
    if (in_valid) begin
      unique case (hs_q)
        HD_HUNT: if (in_byte == HDR_SYNC) hs_d = HD_SYNC;
        HD_SYNC: begin
          if (in_byte == HDR_ZERO)      hs_d = HD_ZERO;
          else if (in_byte != HDR_SYNC) hs_d = HD_HUNT;
        end
        HD_ZERO: begin
          if (in_byte == HDR_SYNC) hs_d = HD_SYNC;
          else begin
            emit_d = 1'b1;
            hs_d   = HD_HUNT;
          end
        end
        default: hs_d = HD_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q      <= HD_HUNT;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
    end else begin
      hs_q      <= hs_d;
      cmd_valid <= emit_d;
      if (emit_d) cmd_byte <= in_byte;
    end
  end
endmodule

// File: rtl/hcs_watchdog.sv
module hcs_watchdog #(
  parameter int LIMIT = 1000000,
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic kick,
  output logic expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_limit;

  assign at_limit = (cnt_q == CNT_W'(LIMIT - 1));
  assign expire   = arm && !kick && at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (!arm || kick)   cnt_d = '0;
    else if (!at_limit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/hcs_reply_tx.sv
module hcs_reply_tx
  import hcs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t payload,
  input  logic  out_ready,
  output logic  out_valid,
  output byte_t out_data,
  output logic  done
);
  tx_phase_t ph_q, ph_d;
  byte_t     data_q;
  logic      fire;

  assign out_valid = (ph_q != TX_IDLE);
  assign out_data  = (ph_q == TX_EOT) ? EOT_BYTE : data_q;
  assign fire      = out_valid && out_ready;
  assign done      = (ph_q == TX_EOT) && out_ready;

  always_comb begin
    ph_d = ph_q;
    if (load)      ph_d = TX_PAYLOAD;
    else if (fire) ph_d = (ph_q == TX_PAYLOAD) ? TX_EOT : TX_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= TX_IDLE;
      data_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (load) data_q <= payload;
    end
  end
endmodule

// File: rtl/host_cmd_seq.sv
module host_cmd_seq
  import hcs_pkg::*;
#(
  parameter int WDT_CYCLES = 1000000,
  parameter int RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_ready,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       pwr_up_start,
  input  logic       pwr_up_done,
  output logic       pwr_dn_start,
  input  logic       pwr_dn_done,
  output logic       refresh_start,
  input  logic       refresh_done,
  output logic       test_start,
  input  logic       test_done,
  input  logic       test_pass,
  output logic       amps_on,
  output logic       wdt_fault
);
  logic       rst_n_s;
  logic       cmd_valid;
  byte_t      cmd_byte;
  logic       kick, expire, reply_load, reply_done;
  byte_t      reply_byte, status_byte;
  ctl_state_t st_q, st_d, ret_q, ret_d;
  logic       wdt_set, tst_upd;
  logic       amps_q, wdt_err_q, tst_ran_q, tst_fail_q;

  hcs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  hcs_frame_detect u_frame (
    .clk(clk), .rst_n(rst_n_s), .in_valid(rx_valid), .in_byte(rx_data),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte)
  );

  assign kick = (st_q == ST_IDLE) && cmd_valid && cmd_known(cmd_byte);

  hcs_watchdog #(.LIMIT(WDT_CYCLES)) u_wdt (
    .clk(clk), .rst_n(rst_n_s), .arm(st_q == ST_IDLE), .kick(kick), .expire(expire)
  );

  assign status_byte = {4'b0000, tst_ran_q, tst_fail_q, wdt_err_q, amps_q};
  assign reply_load  = (st_d == ST_REPLY) && (st_q != ST_REPLY);

  hcs_reply_tx u_tx (
    .clk(clk), .rst_n(rst_n_s), .load(reply_load), .payload(reply_byte),
    .out_ready(tx_ready), .out_valid(tx_valid), .out_data(tx_data), .done(reply_done)
  );

  always_comb begin
    st_d       = st_q;
    ret_d      = ret_q;
    reply_byte = status_byte;
    wdt_set    = 1'b0;
    tst_upd    = 1'b0;
    unique case (st_q)
      ST_BOOT:    if (link_ready)   st_d = ST_PWRUP;
      ST_PWRUP:   if (pwr_up_done)  st_d = ST_IDLE;
      ST_IDLE: begin
        if (kick) begin
          case (cmd_byte)
            CMD_REFRESH: st_d = ST_REFRESH;
            CMD_SELFTST: st_d = ST_TEST;
            CMD_PWRDOWN: st_d = ST_PWRDN;
            CMD_STATUS: begin
              st_d  = ST_REPLY;
              ret_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
          endcase
        end else if (expire) begin
          st_d    = ST_PWRDN;
          wdt_set = 1'b1;
        end
      end
      ST_REFRESH: if (refresh_done) st_d = ST_IDLE;
      ST_TEST: begin
        if (test_done) begin
          st_d       = ST_REPLY;
          ret_d      = ST_IDLE;
          reply_byte = {7'd0, test_pass};
          tst_upd    = 1'b1;
        end
      end
      ST_REPLY:   if (reply_done)  st_d = ret_q;
      ST_PWRDN:   if (pwr_dn_done) st_d = ST_OFF;
      ST_OFF: begin
        if (cmd_valid && cmd_byte == CMD_STATUS) begin
          st_d  = ST_REPLY;
          ret_d = ST_OFF;
        end
      end
      default: st_d = ST_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q          <= ST_BOOT;
      ret_q         <= ST_IDLE;
      amps_q        <= 1'b0;
      wdt_err_q     <= 1'b0;
      tst_ran_q     <= 1'b0;
      tst_fail_q    <= 1'b0;
      pwr_up_start  <= 1'b0;
      pwr_dn_start  <= 1'b0;
      refresh_start <= 1'b0;
      test_start    <= 1'b0;
    end else begin
      st_q          <= st_d;
      ret_q         <= ret_d;
      pwr_up_start  <= (st_d == ST_PWRUP)   && (st_q != ST_PWRUP);
      pwr_dn_start  <= (st_d == ST_PWRDN)   && (st_q != ST_PWRDN);
      refresh_start <= (st_d == ST_REFRESH) && (st_q != ST_REFRESH);
      test_start    <= (st_d == ST_TEST)    && (st_q != ST_TEST);
      if (st_q == ST_PWRUP && pwr_up_done)               amps_q <= 1'b1;
      else if (st_d == ST_PWRDN && st_q != ST_PWRDN)     amps_q <= 1'b0;
      if (wdt_set) wdt_err_q <= 1'b1;
      if (tst_upd) begin
        tst_ran_q  <= 1'b1;
        tst_fail_q <= !test_pass;
      end
    end
  end

  assign amps_on   = amps_q;
  assign wdt_fault = wdt_err_q;
endmodule

// File: rtl/host_cmd_seq_chk.sv
module host_cmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       link_ready,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       pwr_up_start,
  input logic       pwr_dn_start,
  input logic       refresh_start,
  input logic       test_start,
  input logic       amps_on,
  input logic       wdt_fault
);
  logic       ready_seen_q;
  logic [3:0] starts;

  assign starts = {pwr_up_start, pwr_dn_start, refresh_start, test_start};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ready_seen_q <= 1'b0;
    else if (link_ready) ready_seen_q <= 1'b1;
  end

  p_one_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(starts));

  p_short_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|starts) |=> (starts == 4'b0000));

  p_tx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_pwrup_after_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up_start |-> ready_seen_q);

  p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_fault |=> wdt_fault);

  p_fault_with_pwrdn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_fault) |-> pwr_dn_start);

  p_amps_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(amps_on) |-> pwr_dn_start);
endmodule

bind host_cmd_seq host_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .link_ready(link_ready),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .pwr_up_start(pwr_up_start), .pwr_dn_start(pwr_dn_start),
  .refresh_start(refresh_start), .test_start(test_start),
  .amps_on(amps_on), .wdt_fault(wdt_fault)
);

// File: tb/host_cmd_seq_test.sv
module host_cmd_seq_test;
  localparam int WDT = 300;

  logic clk = 1'b0;
  logic rst_n, link_ready, rx_valid, tx_ready;
  logic [7:0] rx_data;
  logic tx_valid;
  logic [7:0] tx_data;
  logic pwr_up_start, pwr_up_done, pwr_dn_start, pwr_dn_done;
  logic refresh_start, refresh_done, test_start, test_done, test_pass;
  logic amps_on, wdt_fault;
  logic stall_mode;

  always #2 clk = ~clk;

  host_cmd_seq #(.WDT_CYCLES(WDT)) uut (
    .clk(clk), .rst_n(rst_n), .link_ready(link_ready),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .pwr_up_start(pwr_up_start), .pwr_up_done(pwr_up_done),
    .pwr_dn_start(pwr_dn_start), .pwr_dn_done(pwr_dn_done),
    .refresh_start(refresh_start), .refresh_done(refresh_done),
    .test_start(test_start), .test_done(test_done), .test_pass(test_pass),
    .amps_on(amps_on), .wdt_fault(wdt_fault)
  );

  int checks = 0, fails = 0;
  int n_up = 0, n_dn = 0, n_ref = 0, n_tst = 0;
  int tx_n = 0, hold_err = 0, multi_err = 0;
  logic [7:0] tx_buf [0:63];
  logic prev_stall = 1'b0, prev_any = 1'b0;
  logic [7:0] prev_data = 8'h00;
  bit m_ran = 0, m_fail = 0;

  // Output monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (pwr_up_start)  n_up++;
      if (pwr_dn_start)  n_dn++;
      if (refresh_start) n_ref++;
      if (test_start)    n_tst++;
      if ($countones({pwr_up_start, pwr_dn_start, refresh_start, test_start}) > 1) multi_err++;
      if (prev_any && (pwr_up_start | pwr_dn_start | refresh_start | test_start)) multi_err++;
      prev_any = pwr_up_start | pwr_dn_start | refresh_start | test_start;
      if (prev_stall && (!tx_valid || tx_data != prev_data)) hold_err++;
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      if (tx_valid && tx_ready) begin
        tx_buf[tx_n[5:0]] = tx_data;
        tx_n++;
      end
    end else begin
      prev_stall = 1'b0;
      prev_any   = 1'b0;
    end
  end

  // Reply back-pressure, changed away from both clock edges
  initial begin
    tx_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      tx_ready = stall_mode ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] c);
    send_byte(8'hFF);
    send_byte(8'h00);
    send_byte(c);
  endtask

  task automatic clear_counts;
    n_up = 0; n_dn = 0; n_ref = 0; n_tst = 0; tx_n = 0;
  endtask

  task automatic expect_reply(input string req, input logic [7:0] b0);
    for (int i = 0; i < 200 && tx_n < 2; i++) @(negedge clk);
    chk(req, tx_n, 2);
    chk(req, tx_buf[0], b0);
    chk(req, tx_buf[1], 8'h04);
  endtask

  task automatic pulse_test_done(input logic p);
    test_pass = p;
    test_done = 1'b1;
    @(negedge clk);
    test_done = 1'b0;
  endtask

  task automatic pulse_refresh_done;
    refresh_done = 1'b1;
    @(negedge clk);
    refresh_done = 1'b0;
  endtask

  function automatic logic [7:0] status_exp(input bit amps, input bit wdt);
    return {4'b0000, m_ran, m_fail, wdt, amps};
  endfunction

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [7:0] pool [0:5];
    logic [7:0] cmds [0:3];
    pool = '{8'hFF, 8'h00, 8'h07, 8'h3C, 8'h10, 8'h80};
    cmds = '{8'h01, 8'h02, 8'h05, 8'h06};
    void'($urandom(32'd20231));
    stall_mode = 1'b0;
    rst_n = 1'b0; link_ready = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    pwr_up_done = 1'b0; pwr_dn_done = 1'b0; refresh_done = 1'b0;
    test_done = 1'b0; test_pass = 1'b0;
    idle(3);
    // R1: reset state
    chk("R1", {tx_valid, pwr_up_start, pwr_dn_start, refresh_start, test_start, amps_on, wdt_fault}, 0);
    rst_n = 1'b1;
    idle(10);
    // R2: commands before link ready do nothing
    send_frame(8'h01);
    idle(10);
    chk("R2", n_up + n_ref, 0);
    link_ready = 1'b1;
    idle(5);
    chk("R2", n_up, 1);
    idle(3);
    pwr_up_done = 1'b1; @(negedge clk); pwr_up_done = 1'b0;
    idle(2);
    chk("R2", amps_on, 1);

    // R3: refresh start timing, R6: busy ignores frames
    clear_counts();
    send_frame(8'h01);
    @(negedge clk);
    chk("R3", refresh_start, 1);
    @(negedge clk);
    chk("R12", refresh_start, 0);
    send_frame(8'h05);
    idle(4);
    chk("R6", tx_n, 0);
    pulse_refresh_done();
    idle(2);
    send_frame(8'h01);
    idle(2);
    chk("R6", n_ref, 2);
    pulse_refresh_done();
    idle(2);

    // R4: header resynchronisation
    clear_counts();
    send_byte(8'hFF); send_byte(8'h01); send_byte(8'h02);
    idle(5);
    chk("R4", n_ref + n_tst + n_dn + tx_n, 0);
    send_byte(8'hFF); send_byte(8'hFF); send_byte(8'h00); send_byte(8'h01);
    @(negedge clk);
    chk("R4", refresh_start, 1);
    pulse_refresh_done();
    idle(2);
    send_byte(8'hFF); send_byte(8'h00); send_frame(8'h02);
    @(negedge clk);
    chk("R4", test_start, 1);
    idle(2);
    tx_n = 0;
    pulse_test_done(1'b0);
    m_ran = 1; m_fail = 1;
    expect_reply("R7", 8'h00);
    idle(2);

    // R5: undefined control bytes
    clear_counts();
    send_frame(8'h00); send_frame(8'h07); send_frame(8'h80);
    idle(5);
    chk("R5", n_ref + n_tst + n_dn + n_up + tx_n, 0);

    // R8: status in idle
    send_frame(8'h05);
    expect_reply("R8", status_exp(1, 0));
    idle(2);

    // R7: passing self-test
    tx_n = 0;
    send_frame(8'h02);
    idle(3);
    pulse_test_done(1'b1);
    m_ran = 1; m_fail = 0;
    expect_reply("R7", 8'h01);
    idle(2);

    // Constrained random: noise then a frame, with reply stalls (R9)
    stall_mode = 1'b1;
    for (int it = 0; it < 24; it++) begin
      int nlen;
      logic [7:0] c;
      nlen = $urandom % 6;
      for (int k = 0; k < nlen; k++) send_byte(pool[$urandom % 6]);
      c = cmds[$urandom % 4];
      clear_counts();
      send_frame(c);
      @(negedge clk);
      case (c)
        8'h01: begin
          chk("R3", refresh_start, 1);
          idle($urandom % 4);
          pulse_refresh_done();
        end
        8'h02: begin
          logic p;
          chk("R7", test_start, 1);
          p = 1'($urandom % 2);
          idle($urandom % 4);
          pulse_test_done(p);
          m_ran = 1; m_fail = !p;
          expect_reply("R7", {7'd0, p});
        end
        8'h05: expect_reply("R8", status_exp(1, 0));
        default: begin
          idle(4);
          chk("R3", n_ref + n_tst + n_dn + tx_n, 0);
        end
      endcase
      idle(2);
    end
    stall_mode = 1'b0;
    idle(4);

    // R11: watchdog kept alive, then expiry exactly at the limit
    clear_counts();
    for (int k = 0; k < 3; k++) begin
      send_frame(8'h06);
      idle(200);
    end
    chk("R11", n_dn, 0);
    send_frame(8'h06);
    send_frame(8'h07);
    idle(297);
    chk("R11", pwr_dn_start, 0);
    @(negedge clk);
    chk("R11", pwr_dn_start, 1);
    chk("R11", wdt_fault, 1);
    chk("R10", amps_on, 0);
    idle(3);
    pwr_dn_done = 1'b1; @(negedge clk); pwr_dn_done = 1'b0;
    idle(2);
    clear_counts();
    send_frame(8'h01);
    send_frame(8'h02);
    idle(4);
    chk("R10", n_ref + n_tst + tx_n, 0);
    send_frame(8'h05);
    expect_reply("R10", status_exp(0, 1));
    idle(3);
    chk("R11", wdt_fault, 1);

    // Second reset, explicit power-down
    rst_n = 1'b0;
    idle(2);
    chk("R1", {tx_valid, amps_on, wdt_fault}, 0);
    m_ran = 0; m_fail = 0;
    clear_counts();
    rst_n = 1'b1;
    idle(6);
    chk("R2", n_up, 1);
    pwr_up_done = 1'b1; @(negedge clk); pwr_up_done = 1'b0;
    idle(2);
    send_frame(8'h03);
    @(negedge clk);
    chk("R10", pwr_dn_start, 1);
    chk("R10", amps_on, 0);
    chk("R11", wdt_fault, 0);
    idle(2);
    pwr_dn_done = 1'b1; @(negedge clk); pwr_dn_done = 1'b0;
    idle(2);
    tx_n = 0;
    send_frame(8'h05);
    expect_reply("R8", status_exp(0, 0));
    idle(4);

    chk("R9", hold_err, 0);
    chk("R12", multi_err, 0);
    finish_run();
  end
endmodule